// File: doc/BRIEF.md
# Linked-Descriptor DMA Queue Channel

This block is one DMA channel that works through a chain of descriptors kept in a small descriptor memory inside the block. Each descriptor is four 32-bit words: a link to the next descriptor, a buffer address, a buffer size and a control word with flags and the packet length. Software fills the memory through a simple write port, then starts the channel by writing the byte address of the first descriptor to the head register. The engine checks that it owns each descriptor, starts a transfer, hands the descriptor back by rewriting its control word, and follows the link. A null link ends the chain and marks the last descriptor as the end of the queue.

Software learns of each finished descriptor through a one-cycle event pulse and the completion pointer, which holds the address of the last descriptor handed back. It acknowledges by writing that address back. A channel can be torn down at any time by writing its channel number to the teardown register. The engine then finishes the descriptor in flight, flags it as torn down, loads a fixed marker into the completion pointer and waits for software to write the same marker back. A self-clearing soft-reset bit returns the pointers and the state to their start values without touching the memory. The payload mover is not part of the block: a counter of fixed length stands in for it and produces the transfer-done pulse.

Top module: `ldq_channel`

## Requirements
- R1: After reset, busy, head_ptr, comp_ptr, comp_evt, comp_pend, td_wait, srst_flag and xfer_go are all zero.
- R2: A register write with reg_sel = 0 (head) of a nonzero byte address while the channel is idle makes busy high after the same clock edge, and head_ptr shows that address; a head write of zero is ignored.
- R3: A head write while the channel is busy (running or waiting for a teardown acknowledgement) is ignored: head_ptr keeps its value and the named descriptor is left untouched.
- R4: When the transfer of an owned descriptor finishes, the engine rewrites its control word (word 3) with owner bit 29 cleared, end-of-queue bit 28 set if and only if its link word (word 0) is zero at that moment, and all other bits unchanged; in the same cycle comp_ptr takes the descriptor's byte address and comp_evt is high for one cycle. The hand-back falls LAT+1 clock edges after the edge that started the descriptor's fetch.
- R5: After handing back a descriptor with a nonzero link, the engine fetches the linked descriptor in the next cycle (head_ptr shows it); after the last one busy falls and head_ptr is zero.
- R6: A descriptor whose owner bit 29 is clear ends the run without any transfer: no xfer_go, no event, the control word is not rewritten, and busy and head_ptr are zero one cycle later.
- R7: A register write with reg_sel = 2 (teardown) carrying the channel number CHAN_ID while idle loads 0xFFFFFFFC into comp_ptr, pulses comp_evt once, sets comp_pend and enters the teardown-wait state (td_wait and busy high, head_ptr zero).
- R8: A teardown request during a transfer lets that transfer finish; the descriptor is handed back with owner cleared and teardown-complete bit 27 set, comp_ptr becomes 0xFFFFFFFC with one event pulse, the link is not followed and td_wait rises.
- R9: A teardown write whose value differs from CHAN_ID has no effect.
- R10: A register write with reg_sel = 1 (completion) whose value equals comp_ptr clears comp_pend; any other value leaves it set.
- R11: In teardown-wait, a completion write of 0xFFFFFFFC returns the channel to idle with comp_pend clear; other values leave it waiting.
- R12: A register write with reg_sel = 3 and bit 0 set raises srst_flag for exactly one cycle; at the end of that cycle the channel state, head_ptr, comp_ptr and comp_pend return to zero while the descriptor memory keeps its contents.
- R13: In the fetch cycle of an owned descriptor xfer_go is high for one cycle with xfer_buf = word 1, xfer_bufsz = word 2 and xfer_len = bits 10:0 of word 3; word 3 bit 31 marks start of packet and bit 30 end of packet and pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 head, 1 completion, 2 teardown, 3 soft reset |
| reg_wdata | input | 32 | Register write value |
| mem_we | input | 1 | Descriptor memory write strobe |
| mem_waddr | input | log2(DESC_NUM)+2 | Descriptor memory word address for writes |
| mem_wdata | input | 32 | Descriptor memory write value |
| mem_raddr | input | log2(DESC_NUM)+2 | Descriptor memory word address for reads |
| mem_rdata | output | 32 | Descriptor memory read value (combinational) |
| busy | output | 1 | Channel running or waiting for teardown acknowledgement |
| head_ptr | output | 32 | Byte address of the descriptor being processed, zero when idle |
| comp_ptr | output | 32 | Completion pointer |
| comp_evt | output | 1 | One-cycle pulse per handed-back descriptor or teardown |
| comp_pend | output | 1 | Completion not yet acknowledged |
| td_wait | output | 1 | Teardown finished, waiting for acknowledgement |
| srst_flag | output | 1 | Soft reset in progress, clears itself |
| xfer_go | output | 1 | Transfer start pulse to the data mover |
| xfer_buf | output | 32 | Buffer address of the started transfer |
| xfer_bufsz | output | 32 | Buffer size word of the started transfer |
| xfer_len | output | 11 | Packet length of the started transfer |

## Verification
Every result is tied to a known edge: a register write takes effect at the edge that samples it, the fetch of a descriptor sits in the cycle after it is named, xfer_go is visible in that fetch cycle, and the hand-back with its event and pointer lands LAT+1 edges after the start of the fetch, so a chain of L descriptors empties after L*(LAT+1) cycles. The bench drives and samples on the falling edge and numbers the falling edges from the one after a write's sampling edge, checking xfer_go, comp_evt and comp_ptr at every index of a chain rather than waiting for a level. Chains of one to six descriptors are swept, and for teardown during a transfer the request is placed inside the transfer window so that the hand-back index does not move. Descriptor words are read back through the memory port after each run to confirm which control words were rewritten and which were left alone.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  // control word bit positions (decoded by software and the engine alike)
  localparam int BIT_SOP = 31;
  localparam int BIT_EOP = 30;
  localparam int BIT_OWN = 29;
  localparam int BIT_EOQ = 28;
  localparam int BIT_TDC = 27;
  localparam int BIT_CRC = 26;
  localparam int LEN_W   = 11;

  // word positions inside a descriptor
  localparam int W_LINK = 0;
  localparam int W_BUF  = 1;
  localparam int W_SIZE = 2;
  localparam int W_CTRL = 3;

  localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

  localparam logic [1:0] SEL_HEAD = 2'd0;
  localparam logic [1:0] SEL_COMP = 2'd1;
  localparam logic [1:0] SEL_TEAR = 2'd2;
  localparam logic [1:0] SEL_SRST = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_XFER   = 2'd2,
    ST_TDWAIT = 2'd3
  } eng_state_t;

  // control word as written back when a descriptor is returned
  function automatic logic [31:0] retire_ctrl(logic [31:0] ctrl, logic last, logic torn);
    logic [31:0] r;
    r = ctrl;
    r[BIT_OWN] = 1'b0;
    if (last) r[BIT_EOQ] = 1'b1;
    if (torn) r[BIT_TDC] = 1'b1;
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] pkt_len(logic [31:0] ctrl);
    return ctrl[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/dmaq_desc_ram.sv
module dmaq_desc_ram #(
  parameter int DESC_NUM = 8
) (
  input  logic                              clk,
  input  logic                              h_we,
  input  logic [$clog2(DESC_NUM)+1:0]       h_waddr,
  input  logic [31:0]                       h_wdata,
  input  logic [$clog2(DESC_NUM)+1:0]       h_raddr,
  output logic [31:0]                       h_rdata,
  input  logic [$clog2(DESC_NUM)-1:0]       e_rbase,
  output logic [3:0][31:0]                  e_words,
  input  logic                              e_we,
  input  logic [$clog2(DESC_NUM)-1:0]       e_wbase,
  input  logic [31:0]                       e_wctrl
);
  import dmaq_pkg::*;
  localparam int DEPTH = DESC_NUM * 4;

  logic [31:0] mem [DEPTH];

  // engine write is last, so it wins on a same-word collision
  always_ff @(posedge clk) begin
    if (h_we) mem[h_waddr] <= h_wdata;
    if (e_we) mem[{e_wbase, 2'(W_CTRL)}] <= e_wctrl;
  end

  assign h_rdata = mem[h_raddr];

  for (genvar k = 0; k < 4; k++) begin : g_word
    assign e_words[k] = mem[{e_rbase, 2'(k)}];
  end
endmodule

// File: rtl/dmaq_xfer_timer.sv
module dmaq_xfer_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (start)          cnt <= CW'(LAT);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine #(
  parameter int DESC_NUM = 8,
  parameter logic [31:0] CHAN_ID = 32'd0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [31:0]                  reg_wdata,
  input  logic [3:0][31:0]             desc_words,
  output logic [$clog2(DESC_NUM)-1:0]  rd_base,
  output logic                         wr_en,
  output logic [$clog2(DESC_NUM)-1:0]  wr_base,
  output logic [31:0]                  wr_ctrl,
  output logic                         tmr_start,
  output logic                         tmr_clr,
  input  logic                         tmr_done,
  output logic                         busy,
  output logic [31:0]                  head_ptr,
  output logic [31:0]                  comp_ptr,
  output logic                         comp_evt,
  output logic                         comp_pend,
  output logic                         td_wait,
  output logic                         srst_flag,
  output logic                         xfer_go,
  output logic [31:0]                  xfer_buf,
  output logic [31:0]                  xfer_bufsz,
  output logic [10:0]                  xfer_len
);
  import dmaq_pkg::*;
  localparam int IW = $clog2(DESC_NUM);

  eng_state_t  state;
  logic [31:0] cur_ptr;
  logic        td_pend;

  // decoded register events
  logic head_wr, comp_wr, tear_wr, srst_wr;
  assign head_wr = reg_we && (reg_sel == SEL_HEAD);
  assign comp_wr = reg_we && (reg_sel == SEL_COMP);
  assign tear_wr = reg_we && (reg_sel == SEL_TEAR) && (reg_wdata == CHAN_ID);
  assign srst_wr = reg_we && (reg_sel == SEL_SRST) && reg_wdata[0];

  // descriptor view
  logic [31:0] ctrl_now, link_now;
  logic        owned, last, torn, retire, fetch_go, ack_hit;
  assign ctrl_now = desc_words[W_CTRL];
  assign link_now = desc_words[W_LINK];
  assign owned    = ctrl_now[BIT_OWN];
  assign last     = (link_now == '0);
  assign torn     = td_pend || tear_wr;
  assign fetch_go = (state == ST_FETCH) && owned;
  assign retire   = (state == ST_XFER) && tmr_done;
  assign ack_hit  = comp_wr && comp_pend && (reg_wdata == comp_ptr);

  assign rd_base   = cur_ptr[IW+3:4];
  assign wr_base   = cur_ptr[IW+3:4];
  assign wr_en     = retire;
  assign wr_ctrl   = retire_ctrl(ctrl_now, last, torn);
  assign tmr_start = fetch_go;
  assign tmr_clr   = srst_flag;

  assign xfer_go    = fetch_go;
  assign xfer_buf   = desc_words[W_BUF];
  assign xfer_bufsz = desc_words[W_SIZE];
  assign xfer_len   = pkt_len(ctrl_now);

  assign busy     = (state != ST_IDLE);
  assign td_wait  = (state == ST_TDWAIT);
  assign head_ptr = cur_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      comp_ptr  <= '0;
      comp_evt  <= 1'b0;
      comp_pend <= 1'b0;
      td_pend   <= 1'b0;
      srst_flag <= 1'b0;
    end else if (srst_flag) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      comp_ptr  <= '0;
      comp_evt  <= 1'b0;
      comp_pend <= 1'b0;
      td_pend   <= 1'b0;
      srst_flag <= 1'b0;
    end else begin
      comp_evt  <= 1'b0;
      srst_flag <= srst_wr;
      if (ack_hit) comp_pend <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tear_wr) begin
            state     <= ST_TDWAIT;
            comp_ptr  <= TD_MARK;
            comp_evt  <= 1'b1;
            comp_pend <= 1'b1;
          end else if (head_wr && reg_wdata != '0) begin
            state   <= ST_FETCH;
            cur_ptr <= reg_wdata;
          end
        end
        ST_FETCH: begin
          if (owned) begin
            state <= ST_XFER;
            if (tear_wr) td_pend <= 1'b1;
          end else if (torn) begin
            state     <= ST_TDWAIT;
            cur_ptr   <= '0;
            td_pend   <= 1'b0;
            comp_ptr  <= TD_MARK;
            comp_evt  <= 1'b1;
            comp_pend <= 1'b1;
          end else begin
            state   <= ST_IDLE;
            cur_ptr <= '0;
          end
        end
        ST_XFER: begin
          if (retire) begin
            comp_evt  <= 1'b1;
            comp_pend <= 1'b1;
            if (torn) begin
              state    <= ST_TDWAIT;
              cur_ptr  <= '0;
              td_pend  <= 1'b0;
              comp_ptr <= TD_MARK;
            end else begin
              comp_ptr <= cur_ptr;
              if (last) begin
                state   <= ST_IDLE;
                cur_ptr <= '0;
              end else begin
                state   <= ST_FETCH;
                cur_ptr <= link_now;
              end
            end
          end else if (tear_wr) begin
            td_pend <= 1'b1;
          end
        end
        ST_TDWAIT: begin
          if (comp_wr && reg_wdata == TD_MARK) begin
            state     <= ST_IDLE;
            comp_pend <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_head_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> head_ptr == '0);
  p_tdwait_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    td_wait |-> comp_ptr == TD_MARK);
  p_evt_sets_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    comp_evt |-> comp_pend);
  p_srst_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_flag |=> !srst_flag);
  p_wb_owner_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_ctrl[BIT_OWN]);
  p_go_then_xfer_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !srst_flag) |=> (busy && !td_wait && !xfer_go));
endmodule

// File: rtl/ldq_channel.sv
module ldq_channel #(
  parameter int DESC_NUM = 8,
  parameter int LAT = 4,
  parameter logic [31:0] CHAN_ID = 32'd0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [31:0]                  reg_wdata,
  input  logic                         mem_we,
  input  logic [$clog2(DESC_NUM)+1:0]  mem_waddr,
  input  logic [31:0]                  mem_wdata,
  input  logic [$clog2(DESC_NUM)+1:0]  mem_raddr,
  output logic [31:0]                  mem_rdata,
  output logic                         busy,
  output logic [31:0]                  head_ptr,
  output logic [31:0]                  comp_ptr,
  output logic                         comp_evt,
  output logic                         comp_pend,
  output logic                         td_wait,
  output logic                         srst_flag,
  output logic                         xfer_go,
  output logic [31:0]                  xfer_buf,
  output logic [31:0]                  xfer_bufsz,
  output logic [10:0]                  xfer_len
);
  localparam int IW = $clog2(DESC_NUM);

  logic [3:0][31:0] desc_words;
  logic [IW-1:0]    rd_base, wr_base;
  logic             wr_en, tmr_start, tmr_clr, tmr_done;
  logic [31:0]      wr_ctrl;

  dmaq_desc_ram #(.DESC_NUM(DESC_NUM)) u_ram (
    .clk     (clk),
    .h_we    (mem_we),
    .h_waddr (mem_waddr),
    .h_wdata (mem_wdata),
    .h_raddr (mem_raddr),
    .h_rdata (mem_rdata),
    .e_rbase (rd_base),
    .e_words (desc_words),
    .e_we    (wr_en),
    .e_wbase (wr_base),
    .e_wctrl (wr_ctrl)
  );

  dmaq_xfer_timer #(.LAT(LAT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .start (tmr_start),
    .done  (tmr_done)
  );

  dmaq_engine #(.DESC_NUM(DESC_NUM), .CHAN_ID(CHAN_ID)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .desc_words (desc_words),
    .rd_base    (rd_base),
    .wr_en      (wr_en),
    .wr_base    (wr_base),
    .wr_ctrl    (wr_ctrl),
    .tmr_start  (tmr_start),
    .tmr_clr    (tmr_clr),
    .tmr_done   (tmr_done),
    .busy       (busy),
    .head_ptr   (head_ptr),
    .comp_ptr   (comp_ptr),
    .comp_evt   (comp_evt),
    .comp_pend  (comp_pend),
    .td_wait    (td_wait),
    .srst_flag  (srst_flag),
    .xfer_go    (xfer_go),
    .xfer_buf   (xfer_buf),
    .xfer_bufsz (xfer_bufsz),
    .xfer_len   (xfer_len)
  );
endmodule

// File: tb/tb_ldq_channel.sv
module tb_ldq_channel;
  localparam int ND  = 8;
  localparam int LAT = 3;
  localparam int CH  = 5;
  localparam int AW  = 5;
  localparam int STEP = LAT + 1;
  localparam logic [31:0] MARK = 32'hFFFF_FFFC;
  localparam logic [31:0] OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000;
  localparam logic [31:0] TDC = 32'h0800_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, mem_we = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, mem_wdata = 0, mem_rdata;
  logic [AW-1:0] mem_waddr = 0, mem_raddr = 0;
  logic busy, comp_evt, comp_pend, td_wait, srst_flag, xfer_go;
  logic [31:0] head_ptr, comp_ptr, xfer_buf, xfer_bufsz;
  logic [10:0] xfer_len;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ldq_channel #(.DESC_NUM(ND), .LAT(LAT), .CHAN_ID(CH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .busy(busy), .head_ptr(head_ptr), .comp_ptr(comp_ptr), .comp_evt(comp_evt),
    .comp_pend(comp_pend), .td_wait(td_wait), .srst_flag(srst_flag), .xfer_go(xfer_go),
    .xfer_buf(xfer_buf), .xfer_bufsz(xfer_bufsz), .xfer_len(xfer_len)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mem_put(input int idx, input logic [31:0] v);
    @(negedge clk);
    mem_we = 1; mem_waddr = idx[AW-1:0]; mem_wdata = v;
    @(negedge clk);
    mem_we = 0;
  endtask

  task automatic mem_get(input int idx, output logic [31:0] v);
    mem_raddr = idx[AW-1:0];
    #1;
    v = mem_rdata;
  endtask

  task automatic reg_put(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic build(input int d, input logic [31:0] link, input logic [31:0] bufa,
                       input logic [31:0] sz, input logic [31:0] ctrl);
    mem_put(4*d + 0, link);
    mem_put(4*d + 1, bufa);
    mem_put(4*d + 2, sz);
    mem_put(4*d + 3, ctrl);
  endtask

  function automatic logic [31:0] ctrl_of(input int len, input bit own);
    return 32'hC000_0000 | (own ? OWN : 32'h0) | 32'(len & 11'h7FF);
  endfunction

  function automatic int len_of(input int i, input int l);
    return (i * 301 + l * 97) % 2048;
  endfunction

  logic [31:0] rd;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 head_ptr", head_ptr, 0);
    check("R1 comp_ptr", comp_ptr, 0);
    check("R1 comp_evt", comp_evt, 0);
    check("R1 comp_pend", comp_pend, 0);
    check("R1 td_wait", td_wait, 0);
    check("R1 srst_flag", srst_flag, 0);
    check("R1 xfer_go", xfer_go, 0);

    // R2 zero head write ignored
    reg_put(2'd0, 32'h0);
    check("R2 zero head ignored", busy, 0);

    // chain sweep: R2 R4 R5 R13 R10
    for (int l = 1; l <= 6; l++) begin
      for (int i = 1; i <= l; i++)
        build(i, (i < l) ? 32'(16 * (i + 1)) : 32'h0, 32'h1000 * i + l, 32'(64 + i),
              ctrl_of(len_of(i, l), 1));
      reg_put(2'd0, 32'd16);
      check("R2 busy after head", busy, 1);
      for (int m = 0; m <= STEP * l; m++) begin
        if (m > 0) @(negedge clk);
        if ((m % STEP) == 0 && m < STEP * l) begin
          int k;
          k = m / STEP + 1;
          check("R13 xfer_go", xfer_go, 1);
          check("R13 xfer_buf", xfer_buf, 32'h1000 * k + l);
          check("R13 xfer_bufsz", xfer_bufsz, 32'(64 + k));
          check("R13 xfer_len", 32'(xfer_len), 32'(len_of(k, l)));
          check("R5 head_ptr follows link", head_ptr, 32'(16 * k));
        end else begin
          check("R13 no xfer_go", xfer_go, 0);
        end
        check("R4 comp_evt timing", comp_evt, (m > 0 && (m % STEP) == 0));
        if (m > 0 && (m % STEP) == 0)
          check("R4 comp_ptr", comp_ptr, 32'(16 * (m / STEP)));
      end
      check("R5 busy drops", busy, 0);
      check("R5 head_ptr zero", head_ptr, 0);
      check("R10 pending", comp_pend, 1);
      for (int i = 1; i <= l; i++) begin
        mem_get(4 * i + 3, rd);
        check("R4 ctrl written back", rd,
              (ctrl_of(len_of(i, l), 1) & ~OWN) | ((i == l) ? EOQ : 32'h0));
      end
      reg_put(2'd1, 32'(16 * l + 4));
      check("R10 wrong ack keeps pend", comp_pend, 1);
      reg_put(2'd1, 32'(16 * l));
      check("R10 ack clears pend", comp_pend, 0);
    end

    // R6 descriptor not owned
    build(1, 32'h0, 32'hAAAA, 32'd8, ctrl_of(20, 0));
    reg_put(2'd0, 32'd16);
    check("R6 fetch cycle busy", busy, 1);
    check("R6 no xfer_go", xfer_go, 0);
    @(negedge clk);
    check("R6 busy low", busy, 0);
    check("R6 head zero", head_ptr, 0);
    check("R6 no event", comp_evt, 0);
    mem_get(7, rd);
    check("R6 ctrl untouched", rd, ctrl_of(20, 0));

    // R3 head write while busy
    build(1, 32'h0, 32'hB001, 32'd8, ctrl_of(9, 1));
    build(5, 32'h0, 32'hB005, 32'd8, ctrl_of(11, 1));
    reg_put(2'd0, 32'd16);
    reg_put(2'd0, 32'h50);
    check("R3 head_ptr kept", head_ptr, 32'd16);
    repeat (STEP - 2) @(negedge clk);
    check("R3 event of first only", comp_evt, 1);
    check("R3 comp_ptr", comp_ptr, 32'd16);
    @(negedge clk);
    check("R3 idle after", busy, 0);
    mem_get(23, rd);
    check("R3 ignored desc untouched", rd, ctrl_of(11, 1));
    reg_put(2'd1, 32'd16);

    // R9 mismatched teardown
    reg_put(2'd2, 32'(CH + 1));
    check("R9 no td_wait", td_wait, 0);
    check("R9 no event", comp_evt, 0);
    check("R9 comp unchanged", comp_ptr, 32'd16);

    // R7 teardown while idle
    reg_put(2'd2, 32'(CH));
    check("R7 td_wait", td_wait, 1);
    check("R7 event", comp_evt, 1);
    check("R7 marker", comp_ptr, MARK);
    check("R7 pend", comp_pend, 1);
    @(negedge clk);
    check("R7 single event", comp_evt, 0);
    reg_put(2'd0, 32'd16);
    check("R3 head ignored in td wait", head_ptr, 0);
    check("R7 still waiting", td_wait, 1);
    reg_put(2'd1, 32'd16);
    check("R11 wrong ack keeps wait", td_wait, 1);
    reg_put(2'd1, MARK);
    check("R11 ack leaves wait", td_wait, 0);
    check("R11 busy low", busy, 0);
    check("R11 pend clear", comp_pend, 0);

    // R8 teardown during transfer
    build(1, 32'd32, 32'hC001, 32'd8, ctrl_of(7, 1));
    build(2, 32'h0, 32'hC002, 32'd8, ctrl_of(8, 1));
    reg_put(2'd0, 32'd16);
    reg_put(2'd2, 32'(CH));
    check("R8 no early event", comp_evt, 0);
    repeat (STEP - 2) @(negedge clk);
    check("R8 event", comp_evt, 1);
    check("R8 marker", comp_ptr, MARK);
    check("R8 td_wait", td_wait, 1);
    @(negedge clk);
    check("R8 single event", comp_evt, 0);
    check("R8 no link followed", head_ptr, 0);
    mem_get(7, rd);
    check("R8 torn ctrl", rd, ctrl_of(7, 0) | TDC);
    mem_get(11, rd);
    check("R8 next untouched", rd, ctrl_of(8, 1));
    reg_put(2'd1, MARK);
    check("R11 ack after R8", td_wait, 0);

    // R12 soft reset
    reg_put(2'd2, 32'(CH));
    reg_put(2'd3, 32'd1);
    check("R12 flag set", srst_flag, 1);
    @(negedge clk);
    check("R12 flag self clear", srst_flag, 0);
    check("R12 td_wait cleared", td_wait, 0);
    check("R12 comp_ptr zero", comp_ptr, 0);
    check("R12 pend zero", comp_pend, 0);
    check("R12 busy zero", busy, 0);
    mem_get(5, rd);
    check("R12 memory kept", rd, 32'hC001);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule